// File: doc/BRIEF.md
# MMC Host Register Front-End

This block is the software-visible face of a simple MMC/SD host controller. A processor reaches it through a 32-bit register port with a valid/ready handshake. Software programs an argument, writes a packed command word, and the block hands that command to a separate command engine over a request/done/timeout handshake. When the engine finishes, the block captures the card's response into four readable words. For commands that move data, it counts completed blocks. It keeps a sticky set of interrupt causes that software clears by writing ones.

The block also samples the card-detect and write-protect inputs and exposes them in a state register. Any change in card presence raises an interrupt cause. Serial line signalling, CRC, clock generation and the data buffer itself sit outside the block. The programmed buffer base address and block length are passed on to that logic.

Top module: `mmc_fe_top`

## Requirements
- R1: After reset every register reads as zero, `irq` is low and `eng_req` is low.
- R2: Word offsets are 0x04 enable (4 bits), 0x08 buffer base (32 bits), 0x10 argument (32 bits), 0x24 block length minus one and 0x28 block count minus one (11 bits each, upper write bits dropped). Each of these reads back what was written. A read returns data with `rsp_valid` one cycle after the request.
- R3: A write to offset 0x0C while idle raises `eng_req` from the next cycle and presents the stored word on `eng_cmd`, with the argument on `eng_arg`. The word holds opcode in bits 5:0, open-drain flag in bit 6, response kind in bits 9:8 (0 none, 1 short, 2 long, 3 short OCR), busy flag in bit 11, command class in bits 13:12 (3 = with data transfer) and read direction in bit 15. Bits 7, 10, 14 and 16 upward are stored as zero.
- R4: A command-register write while a command or its data phase is in progress is ignored, and `eng_cmd` holds still.
- R5: `eng_done` during a request ends it. `eng_req` falls and status bit 0 (end of command) is set.
- R6: On completion, a long response loads 0x14..0x20 with `eng_resp` bits 31:0, 63:32, 95:64 and 127:96. A short or OCR response loads only 0x14. A command with response kind none leaves all four words unchanged.
- R7: `eng_timeout` during a request ends it and sets status bit 3 instead of bit 0, even when `eng_done` is also high. No data phase follows.
- R8: After a class-3 command completes, status bit 1 (end of data) is set on the `data_done` strobe that brings the count to the programmed block count plus one, and not before.
- R9: Status (offset 0x00) is write-one-to-clear per bit. A cause raised in the same cycle as its clear stays set.
- R10: `irq` is high exactly when some status bit is set together with its enable bit. Causes latch while masked.
- R11: State (offset 0x2C) reads the sampled `card_present` in bit 0 and `card_ro` in bit 1. Each cycle in which `card_present` differs from its previous sample sets status bit 2; the sample is zero after reset. A change of `card_ro` alone sets no cause.
- R12: Writes to the response and state offsets have no effect, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Access accepted (always high) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| eng_req | output | 1 | Command pending on the engine |
| eng_cmd | output | 16 | Stored command word |
| eng_arg | output | 32 | Command argument |
| eng_blk_len | output | BLK_W | Block length minus one |
| eng_buf_base | output | 32 | Buffer base address |
| eng_done | input | 1 | Engine finished the command |
| eng_timeout | input | 1 | Engine saw no response |
| eng_resp | input | 128 | Card response |
| data_done | input | 1 | One block transferred |
| card_present | input | 1 | Card detect level |
| card_ro | input | 1 | Write protect level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine raises `eng_done` and `eng_timeout` only as single-cycle pulses while `eng_req` is high. They also assume `data_done` strobes arrive only during a data phase. The stimulus issues these pulses only after `eng_req` has been seen high, and gives exactly the programmed number of block strobes. It leaves the block count alone while a data phase runs.

// File: rtl/mmc_fe_pkg.sv
package mmc_fe_pkg;

    localparam int DATA_W = 32;
    localparam int NRESP  = 4;
    localparam int RESP_W = NRESP * DATA_W;
    localparam int NCAUSE = 4;

    localparam logic [5:0] OFF_STAT  = 6'h00;
    localparam logic [5:0] OFF_EN    = 6'h04;
    localparam logic [5:0] OFF_BASE  = 6'h08;
    localparam logic [5:0] OFF_CMD   = 6'h0C;
    localparam logic [5:0] OFF_ARG   = 6'h10;
    localparam logic [5:0] OFF_RESP0 = 6'h14;
    localparam logic [5:0] OFF_RESP1 = 6'h18;
    localparam logic [5:0] OFF_RESP2 = 6'h1C;
    localparam logic [5:0] OFF_RESP3 = 6'h20;
    localparam logic [5:0] OFF_LEN   = 6'h24;
    localparam logic [5:0] OFF_CNT   = 6'h28;
    localparam logic [5:0] OFF_STATE = 6'h2C;

    localparam int CS_CMD  = 0;
    localparam int CS_DATA = 1;
    localparam int CS_CHG  = 2;
    localparam int CS_TMO  = 3;

    typedef enum logic [1:0] {
        RK_NONE  = 2'd0,
        RK_SHORT = 2'd1,
        RK_LONG  = 2'd2,
        RK_OCR   = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CC_BCAST    = 2'd0,
        CC_BCAST_R  = 2'd1,
        CC_ADDR     = 2'd2,
        CC_ADDR_DAT = 2'd3
    } cmd_class_e;

    typedef struct packed {
        logic       to_host;
        logic       rsv14;
        cmd_class_e cls;
        logic       wait_busy;
        logic       rsv10;
        rsp_kind_e  rsp;
        logic       rsv7;
        logic       open_drain;
        logic [5:0] opcode;
    } cmd_word_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CMD  = 2'd1,
        SQ_DATA = 2'd2
    } seq_state_e;

    function automatic cmd_word_t pack_cmd(input logic [15:0] w);
        cmd_word_t c;
        c = cmd_word_t'(w);
        c.rsv7  = 1'b0;
        c.rsv10 = 1'b0;
        c.rsv14 = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/mmc_fe_seq.sv
module mmc_fe_seq
    import mmc_fe_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [15:0]      cmd_wdata,
    input  logic [BLK_W-1:0] blk_cnt,
    input  logic             eng_done,
    input  logic             eng_timeout,
    input  logic             data_done,
    output logic             eng_req,
    output cmd_word_t        cmd_q,
    output logic [NRESP-1:0] resp_we,
    output logic             ev_cmd,
    output logic             ev_tmo,
    output logic             ev_data
);

    seq_state_e       st;
    logic [BLK_W-1:0] blk_seen;
    logic             last_blk;

    assign last_blk = (blk_seen == blk_cnt);
    assign eng_req  = (st == SQ_CMD);
    assign ev_tmo   = (st == SQ_CMD) && eng_timeout;
    assign ev_cmd   = (st == SQ_CMD) && eng_done && !eng_timeout;
    assign ev_data  = (st == SQ_DATA) && data_done && last_blk;

    always_comb begin
        resp_we = '0;
        if (ev_cmd) begin
            unique case (cmd_q.rsp)
                RK_LONG:          resp_we = '1;
                RK_SHORT, RK_OCR: resp_we[0] = 1'b1;
                default:          resp_we = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            cmd_q    <= '0;
            blk_seen <= '0;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (cmd_wr) begin
                        cmd_q <= pack_cmd(cmd_wdata);
                        st    <= SQ_CMD;
                    end
                end
                SQ_CMD: begin
                    if (eng_timeout) begin
                        st <= SQ_IDLE;
                    end else if (eng_done) begin
                        blk_seen <= '0;
                        st <= (cmd_q.cls == CC_ADDR_DAT) ? SQ_DATA : SQ_IDLE;
                    end
                end
                SQ_DATA: begin
                    if (data_done) begin
                        if (last_blk) st <= SQ_IDLE;
                        else          blk_seen <= blk_seen + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mmc_fe_irq.sv
module mmc_fe_irq
    import mmc_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] ev,
    input  logic              clr_we,
    input  logic [NCAUSE-1:0] clr_mask,
    input  logic [NCAUSE-1:0] enable,
    output logic [NCAUSE-1:0] status,
    output logic              irq
);

    logic [NCAUSE-1:0] kill;

    assign kill = clr_we ? clr_mask : '0;
    assign irq  = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~kill) | ev;
    end

endmodule

// File: rtl/mmc_fe_regs.sv
module mmc_fe_regs
    import mmc_fe_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [5:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NCAUSE-1:0] status,
    input  cmd_word_t         cmd_q,
    input  logic [NRESP-1:0]  resp_we,
    input  logic [RESP_W-1:0] eng_resp,
    input  logic              card_present,
    input  logic              card_ro,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cmd_wr,
    output logic              clr_we,
    output logic [NCAUSE-1:0] clr_mask,
    output logic [NCAUSE-1:0] enable,
    output logic [DATA_W-1:0] arg_q,
    output logic [DATA_W-1:0] base_q,
    output logic [BLK_W-1:0]  len_q,
    output logic [BLK_W-1:0]  cnt_q,
    output logic              ev_chg
);

    logic              wr, rd;
    logic              pres_q, ro_q;
    logic [DATA_W-1:0] resp_q [NRESP];
    logic [DATA_W-1:0] rd_mux;

    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;
    assign cmd_wr   = wr && (req_addr == OFF_CMD);
    assign clr_we   = wr && (req_addr == OFF_STAT);
    assign clr_mask = req_wdata[NCAUSE-1:0];
    assign ev_chg   = (card_present != pres_q);

    for (genvar g = 0; g < NRESP; g++) begin : g_resp
        always_ff @(posedge clk) begin
            if (rst)             resp_q[g] <= '0;
            else if (resp_we[g]) resp_q[g] <= eng_resp[g*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            arg_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            pres_q <= 1'b0;
            ro_q   <= 1'b0;
        end else begin
            pres_q <= card_present;
            ro_q   <= card_ro;
            if (wr) begin
                unique case (req_addr)
                    OFF_EN:   enable <= req_wdata[NCAUSE-1:0];
                    OFF_BASE: base_q <= req_wdata;
                    OFF_ARG:  arg_q  <= req_wdata;
                    OFF_LEN:  len_q  <= req_wdata[BLK_W-1:0];
                    OFF_CNT:  cnt_q  <= req_wdata[BLK_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (req_addr)
            OFF_STAT:  rd_mux[NCAUSE-1:0] = status;
            OFF_EN:    rd_mux[NCAUSE-1:0] = enable;
            OFF_BASE:  rd_mux = base_q;
            OFF_CMD:   rd_mux[15:0] = cmd_q;
            OFF_ARG:   rd_mux = arg_q;
            OFF_RESP0: rd_mux = resp_q[0];
            OFF_RESP1: rd_mux = resp_q[1];
            OFF_RESP2: rd_mux = resp_q[2];
            OFF_RESP3: rd_mux = resp_q[3];
            OFF_LEN:   rd_mux[BLK_W-1:0] = len_q;
            OFF_CNT:   rd_mux[BLK_W-1:0] = cnt_q;
            OFF_STATE: rd_mux[1:0] = {ro_q, pres_q};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd;
            rsp_data  <= rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/mmc_fe_top.sv
module mmc_fe_top
    import mmc_fe_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [5:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              eng_req,
    output logic [15:0]       eng_cmd,
    output logic [DATA_W-1:0] eng_arg,
    output logic [BLK_W-1:0]  eng_blk_len,
    output logic [DATA_W-1:0] eng_buf_base,
    input  logic              eng_done,
    input  logic              eng_timeout,
    input  logic [RESP_W-1:0] eng_resp,
    input  logic              data_done,
    input  logic              card_present,
    input  logic              card_ro,
    output logic              irq
);

    cmd_word_t         cmd_q;
    logic [NRESP-1:0]  resp_we;
    logic [NCAUSE-1:0] st_status, enable, clr_mask, ev;
    logic              cmd_wr, clr_we;
    logic              ev_cmd, ev_tmo, ev_data, ev_chg;
    logic [BLK_W-1:0]  cnt_q;

    assign req_ready = 1'b1;
    assign eng_cmd   = cmd_q;

    always_comb begin
        ev          = '0;
        ev[CS_CMD]  = ev_cmd;
        ev[CS_DATA] = ev_data;
        ev[CS_CHG]  = ev_chg;
        ev[CS_TMO]  = ev_tmo;
    end

    mmc_fe_regs #(.BLK_W(BLK_W)) u_regs (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .status(st_status), .cmd_q(cmd_q),
        .resp_we(resp_we), .eng_resp(eng_resp),
        .card_present(card_present), .card_ro(card_ro),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cmd_wr(cmd_wr), .clr_we(clr_we), .clr_mask(clr_mask),
        .enable(enable), .arg_q(eng_arg), .base_q(eng_buf_base),
        .len_q(eng_blk_len), .cnt_q(cnt_q), .ev_chg(ev_chg)
    );

    mmc_fe_seq #(.BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_wr(cmd_wr), .cmd_wdata(req_wdata[15:0]), .blk_cnt(cnt_q),
        .eng_done(eng_done), .eng_timeout(eng_timeout), .data_done(data_done),
        .eng_req(eng_req), .cmd_q(cmd_q), .resp_we(resp_we),
        .ev_cmd(ev_cmd), .ev_tmo(ev_tmo), .ev_data(ev_data)
    );

    mmc_fe_irq u_irq (
        .clk(clk), .rst(rst),
        .ev(ev), .clr_we(clr_we), .clr_mask(clr_mask),
        .enable(enable), .status(st_status), .irq(irq)
    );

endmodule

// File: rtl/mmc_fe_chk.sv
module mmc_fe_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [5:0]  req_addr,
    input logic        eng_req,
    input logic [15:0] eng_cmd,
    input logic        eng_done,
    input logic        eng_timeout,
    input logic        data_done,
    input logic [3:0]  stat
);

    // R3: a request only starts from a command-register write
    a_r3_launch: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_req) |-> $past(req_valid && req_write && req_addr == 6'h0C));

    // R4: a pending command is not replaced
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        eng_req && !eng_done && !eng_timeout |=> eng_req && $stable(eng_cmd));

    // R5: end-of-command follows a clean completion
    a_r5_end_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[0]) |-> $past(eng_req && eng_done && !eng_timeout));

    // R7: timeout ends the request
    a_r7_timeout_ends: assert property (@(posedge clk) disable iff (rst)
        eng_req && eng_timeout |=> !eng_req);

    // R7: timeout cause only from a timeout pulse
    a_r7_timeout_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[3]) |-> $past(eng_timeout));

    // R8: end-of-data only on a block strobe
    a_r8_end_data: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[1]) |-> $past(data_done));

endmodule

bind mmc_fe_top mmc_fe_chk u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .eng_req(eng_req), .eng_cmd(eng_cmd),
    .eng_done(eng_done), .eng_timeout(eng_timeout),
    .data_done(data_done), .stat(st_status)
);

// File: tb/mmc_fe_top_bench.sv
module mmc_fe_top_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 0, req_write = 0;
    logic [5:0]   req_addr = 0;
    logic [31:0]  req_wdata = 0;
    logic         req_ready, rsp_valid, eng_req, irq;
    logic [31:0]  rsp_data, eng_arg, eng_buf_base;
    logic [15:0]  eng_cmd;
    logic [10:0]  eng_blk_len;
    logic         eng_done = 0, eng_timeout = 0, data_done = 0;
    logic [127:0] eng_resp = '0;
    logic         card_present = 0, card_ro = 0;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mmc_fe_top u_mmc_fe_top (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_arg(eng_arg),
        .eng_blk_len(eng_blk_len), .eng_buf_base(eng_buf_base),
        .eng_done(eng_done), .eng_timeout(eng_timeout), .eng_resp(eng_resp),
        .data_done(data_done), .card_present(card_present), .card_ro(card_ro),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_phase;      // 0 idle, 1 command, 2 data
    int          m_seen;
    logic [3:0]  m_stat, m_en;
    logic [31:0] m_base, m_arg;
    logic [31:0] m_resp [4];
    logic [15:0] m_cmd;
    logic [10:0] m_len, m_cnt;
    logic        m_pres, m_ro, m_rv;
    logic [31:0] m_rd;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_seen = 0; m_stat = 0; m_en = 0; m_base = 0; m_arg = 0;
            foreach (m_resp[i]) m_resp[i] = 0;
            m_cmd = 0; m_len = 0; m_cnt = 0; m_pres = 0; m_ro = 0; m_rv = 0; m_rd = 0;
        end else begin
            int nxt;
            logic [3:0] raise, wipe;
            nxt = m_phase; raise = 0; wipe = 0;
            m_rv = req_valid && !req_write;
            m_rd = 0;
            if (m_rv) begin
                case (req_addr)
                    6'h00: m_rd = {28'd0, m_stat};
                    6'h04: m_rd = {28'd0, m_en};
                    6'h08: m_rd = m_base;
                    6'h0C: m_rd = {16'd0, m_cmd};
                    6'h10: m_rd = m_arg;
                    6'h14: m_rd = m_resp[0];
                    6'h18: m_rd = m_resp[1];
                    6'h1C: m_rd = m_resp[2];
                    6'h20: m_rd = m_resp[3];
                    6'h24: m_rd = {21'd0, m_len};
                    6'h28: m_rd = {21'd0, m_cnt};
                    6'h2C: m_rd = {30'd0, m_ro, m_pres};
                    default: m_rd = 0;
                endcase
            end
            if (m_phase == 1) begin
                if (eng_timeout) begin
                    raise[3] = 1; nxt = 0;
                end else if (eng_done) begin
                    raise[0] = 1;
                    if (m_cmd[9:8] == 2) foreach (m_resp[i]) m_resp[i] = eng_resp[32*i +: 32];
                    else if (m_cmd[9:8] != 0) m_resp[0] = eng_resp[31:0];
                    m_seen = 0;
                    nxt = (m_cmd[13:12] == 3) ? 2 : 0;
                end
            end else if (m_phase == 2 && data_done) begin
                if (m_seen == int'(m_cnt)) begin raise[1] = 1; nxt = 0; end
                else m_seen++;
            end
            if (card_present != m_pres) raise[2] = 1;
            m_pres = card_present;
            m_ro = card_ro;
            if (req_valid && req_write) begin
                case (req_addr)
                    6'h00: wipe = req_wdata[3:0];
                    6'h04: m_en = req_wdata[3:0];
                    6'h08: m_base = req_wdata;
                    6'h0C: if (m_phase == 0) begin m_cmd = req_wdata[15:0] & 16'hBB7F; nxt = 1; end
                    6'h10: m_arg = req_wdata;
                    6'h24: m_len = req_wdata[10:0];
                    6'h28: m_cnt = req_wdata[10:0];
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~wipe) | raise;
            m_phase = nxt;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R3 eng_req", {31'd0, eng_req}, {31'd0, m_phase == 1});
            chk("R10 irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
            chk("R2 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
            if (m_rv) chk("R2 rsp_data", rsp_data, m_rd);
            if (m_phase == 1) begin
                chk("R3 eng_cmd", {16'd0, eng_cmd}, {16'd0, m_cmd});
                chk("R3 eng_arg", eng_arg, m_arg);
            end
        end
    end

    // ---------------- stimulus tasks (entered just after a negedge) ----------------
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk(tag, rsp_data, exp);
    endtask

    task automatic done_pulse(input logic [127:0] r);
        eng_resp = r; eng_done = 1;
        @(negedge clk);
        eng_done = 0;
    endtask

    task automatic tmo_pulse(input logic with_done);
        eng_timeout = 1; eng_done = with_done;
        @(negedge clk);
        eng_timeout = 0; eng_done = 0;
    endtask

    task automatic blk_pulse();
        data_done = 1;
        @(negedge clk);
        data_done = 0;
    endtask

    localparam logic [127:0] RA = 128'h44444444_33333333_22222222_11111111;
    localparam logic [127:0] RB = 128'hD00DD00D_C0FFEE00_BEEFBEEF_A5A5A5A5;

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 eng_req", {31'd0, eng_req}, 0);
        for (int a = 0; a < 12; a++) rd(6'(a * 4), 0, "R1 reset reg");

        // R2 plain registers
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, 32'hF, "R2 enable");
        wr(6'h08, 32'hDEAD_BEEF); rd(6'h08, 32'hDEAD_BEEF, "R2 base");
        chk("R2 eng_buf_base", eng_buf_base, 32'hDEAD_BEEF);
        wr(6'h24, 32'hFFFF_F9FF); rd(6'h24, 32'h1FF, "R2 block length");
        wr(6'h28, 32'd2);         rd(6'h28, 32'd2, "R2 block count");

        // R12 ignored writes and unmapped reads
        wr(6'h14, 32'h1234); rd(6'h14, 0, "R12 resp write ignored");
        wr(6'h2C, 32'h3);    rd(6'h2C, 0, "R12 state write ignored");
        rd(6'h30, 0, "R12 unmapped"); rd(6'h3C, 0, "R12 unmapped");

        // R3 launch with reserved bits forced to zero
        wr(6'h10, 32'hCAFE_F00D);
        wr(6'h0C, 32'h0000_FDD1);
        chk("R3 eng_req high", {31'd0, eng_req}, 1);
        chk("R3 eng_cmd word", {16'd0, eng_cmd}, 32'hB951);
        chk("R3 eng_arg", eng_arg, 32'hCAFE_F00D);
        // R4 write while busy
        wr(6'h0C, 32'h0000_0002);
        chk("R4 eng_cmd held", {16'd0, eng_cmd}, 32'hB951);
        rd(6'h0C, 32'hB951, "R4 cmd readback");
        // R5/R6 short response
        done_pulse(RA);
        chk("R5 eng_req low", {31'd0, eng_req}, 0);
        chk("R5 irq", {31'd0, irq}, 1);
        rd(6'h00, 32'h1, "R5 end of command");
        rd(6'h14, 32'h1111_1111, "R6 short word0");
        rd(6'h18, 0, "R6 short word1 untouched");
        // R4 during data phase
        wr(6'h0C, 32'h0000_0005);
        chk("R4 ignored in data phase", {31'd0, eng_req}, 0);
        // R9 clear
        wr(6'h00, 32'h1); rd(6'h00, 0, "R9 cleared");
        // R8 three blocks
        blk_pulse(); blk_pulse();
        rd(6'h00, 0, "R8 not yet");
        blk_pulse();
        rd(6'h00, 32'h2, "R8 end of data");

        // R6 long response
        wr(6'h0C, 32'h0000_2202);
        done_pulse(RB);
        rd(6'h14, 32'hA5A5_A5A5, "R6 long word0");
        rd(6'h18, 32'hBEEF_BEEF, "R6 long word1");
        rd(6'h1C, 32'hC0FF_EE00, "R6 long word2");
        rd(6'h20, 32'hD00D_D00D, "R6 long word3");
        wr(6'h00, 32'h2); rd(6'h00, 32'h1, "R9 partial clear");
        wr(6'h00, 32'h1);
        // R9 set wins over clear; R6 none keeps words
        wr(6'h0C, 32'h0000_0000);
        req_valid = 1; req_write = 1; req_addr = 6'h00; req_wdata = 32'h1;
        eng_resp = RA; eng_done = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0; eng_done = 0;
        rd(6'h00, 32'h1, "R9 set beats clear");
        rd(6'h14, 32'hA5A5_A5A5, "R6 none keeps words");

        // R7/R10 timeout while masked
        wr(6'h00, 32'hF); wr(6'h04, 32'h0);
        wr(6'h0C, 32'h0000_0301);
        tmo_pulse(1'b1);
        chk("R7 eng_req low", {31'd0, eng_req}, 0);
        rd(6'h00, 32'h8, "R7 timeout only");
        chk("R10 masked irq", {31'd0, irq}, 0);
        wr(6'h04, 32'h8);
        chk("R10 unmasked irq", {31'd0, irq}, 1);
        // R7 data command timeout leaves block idle
        wr(6'h00, 32'hF);
        wr(6'h0C, 32'h0000_3011);
        tmo_pulse(1'b0);
        wr(6'h0C, 32'h0000_0301);
        chk("R7 no data phase", {31'd0, eng_req}, 1);
        done_pulse(RB);
        rd(6'h14, 32'hA5A5_A5A5, "R6 ocr word0");
        rd(6'h18, 32'hBEEF_BEEF, "R6 ocr word1 kept");

        // R11 card state
        wr(6'h00, 32'hF); wr(6'h04, 32'h4);
        card_present = 1;
        @(negedge clk);
        chk("R11 change irq", {31'd0, irq}, 1);
        rd(6'h2C, 32'h1, "R11 present");
        wr(6'h00, 32'h4);
        card_ro = 1;
        @(negedge clk);
        rd(6'h2C, 32'h3, "R11 read-only");
        rd(6'h00, 0, "R11 ro no cause");
        card_present = 0;
        @(negedge clk);
        rd(6'h00, 32'h4, "R11 removal cause");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule